// File: doc/BRIEF.md
# Hex Record Stripping Filter

This block turns a hex-record flash image, fed in one ASCII character at a time, into the raw byte stream that goes into a serial configuration flash. It works by line position and fixed character counts, without parsing record types. The first line is dropped. Every line whose position is a multiple of a period is dropped, because those lines carry address records. The final line is also dropped. On every kept line, a fixed-length prefix is removed from the front and the two checksum characters are removed from the end. The characters left over are read in pairs and converted into bytes.

The filter cannot tell which line is last until end-of-file arrives. It therefore buffers one line of decoded bytes. A line is released downstream only when the first character of the following line is offered. If `eof` is raised first, the buffered line is discarded.

The controller has five states. ST_WAIT sits between lines: it swallows stray line ends and sees either the start of the next line or `eof`. ST_HEAD counts off the prefix characters. ST_BODY decodes hex pairs into the line store. ST_SEND drains the pending line to the output. ST_STOP is entered on `eof` and is held until reset.

The transitions are:
- ST_WAIT to ST_SEND: a new line starts and a kept line is pending.
- ST_WAIT to ST_HEAD: a new line starts and nothing is pending.
- ST_HEAD to ST_BODY: the last prefix character is taken.
- ST_HEAD or ST_BODY to ST_WAIT: a line end is taken.
- ST_SEND to ST_HEAD: the last byte is accepted downstream.
- Any state except ST_SEND to ST_STOP: `eof` is seen.

Top module: `mcs_strip`

## Requirements
- R1: The first line after reset is never emitted, whatever it contains.
- R2: Lines are counted from zero. A line whose index is a multiple of PERIOD (default 4097) produces no output.
- R3: When `eof` is high outside ST_SEND, the buffered line and any partial line are discarded. From then on `in_ready` stays 0 until reset.
- R4: On a kept line, the first PREFIX characters (default 9) are dropped. The last decoded pair, which is the two checksum characters before the line end, is also dropped.
- R5: CR (0x0D) and LF (0x0A) end a line and are never emitted. A line end that arrives with no characters since the previous one does not count as a line.
- R6: Characters after the prefix are paired. Each pair of hex digits (0-9, A-F, a-f) becomes one byte, and the first digit of the pair is the high nibble.
- R7: A line's bytes are presented only after a non-line-end character of the next line has been offered. While bytes are being presented, `in_ready` is 0.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` is held.
- R9: `fmt_err` goes to 1 and stays there until reset in any of three cases: a non-hex character after the prefix, an odd number of digits after the prefix, or more than MAX_BYTES pairs on one line.
- R10: After reset, `out_valid` and `fmt_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | ASCII character in |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Character taken when also valid |
| eof | input | 1 | No further characters follow |
| out_data | output | 8 | Decoded data byte |
| out_valid | output | 1 | Byte offered |
| out_ready | input | 1 | Downstream accepts the byte |
| fmt_err | output | 1 | Sticky format error |

## Verification
The bench builds the filter with PERIOD=3, PREFIX=9 and MAX_BYTES=8. A period of 3 means a dropped address line occurs after only a few records, so a miscount caused by a blank line shows up as extra bytes. A store of 8 bytes lets a single line of ten pairs reach the overflow error. Downstream stalls are applied on every third cycle, which exercises the hold behaviour during each drain.

// File: rtl/mcs_strip_pkg.sv
package mcs_strip_pkg;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_HEAD,
        ST_BODY,
        ST_SEND,
        ST_STOP
    } strip_state_t;

    function automatic logic is_line_end(input logic [7:0] c);
        return (c == 8'h0D) || (c == 8'h0A);
    endfunction

    // {valid, nibble}
    function automatic logic [4:0] hex_nibble(input logic [7:0] c);
        logic [4:0] r;
        r = 5'b0;
        if (c >= 8'h30 && c <= 8'h39)
            r = {1'b1, c[3:0]};
        else if ((c >= 8'h41 && c <= 8'h46) || (c >= 8'h61 && c <= 8'h66))
            r = {1'b1, c[3:0] + 4'd9};
        return r;
    endfunction

endpackage

// File: rtl/mcs_line_index.sv
module mcs_line_index #(
    parameter int PERIOD = 4097
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic keep
);
    localparam int IW = $clog2(PERIOD);

    logic [IW-1:0] idx;

    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (advance)
            idx <= (idx == IW'(PERIOD - 1)) ? '0 : idx + 1'b1;
    end

    assign keep = (idx != '0);

    // R2: the position counter never leaves its modulo range
    assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(idx) < PERIOD);

endmodule

// File: rtl/mcs_line_store.sv
module mcs_line_store #(
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         wr_en,
    input  logic [7:0]                   wr_data,
    input  logic [$clog2(DEPTH)-1:0]     rd_idx,
    output logic [7:0]                   rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0] mem [DEPTH];

    assign full = (count == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            count <= '0;
        else if (wr_en && !full)
            count <= count + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !full && !clear)
            mem[count[AW-1:0]] <= wr_data;
    end

    assign rd_data = mem[rd_idx];

    // R9: fill level bounded by the store depth
    assert_fill_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count) <= DEPTH);

endmodule

// File: rtl/mcs_strip.sv
module mcs_strip
    import mcs_strip_pkg::*;
#(
    parameter int PERIOD    = 4097,
    parameter int PREFIX    = 9,
    parameter int MAX_BYTES = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       eof,
    output logic [7:0] out_data,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       fmt_err
);
    localparam int PW = $clog2(PREFIX + 1);
    localparam int AW = $clog2(MAX_BYTES);
    localparam int CW = $clog2(MAX_BYTES + 1);

    strip_state_t st, st_nx;

    logic [PW-1:0] pre_cnt;
    logic          nib_odd;
    logic [3:0]    nib_hi;
    logic          pend_emit;
    logic [AW-1:0] rd_idx;
    logic          err_q;

    logic          in_eol;
    logic [4:0]    hx;
    logic          in_fire, out_fire;
    logic          line_end, line_start, body_char, wr_en;
    logic          keep;
    logic [CW-1:0] buf_count;
    logic          buf_full;
    logic [7:0]    buf_rd;
    logic          last_rd;

    assign in_eol    = is_line_end(in_data);
    assign hx        = hex_nibble(in_data);
    assign in_fire   = in_valid && in_ready;
    assign out_fire  = out_valid && out_ready;
    assign line_end  = in_fire && in_eol && (st == ST_HEAD || st == ST_BODY);
    assign line_start = (st_nx == ST_HEAD) && (st != ST_HEAD);
    assign body_char = in_fire && !in_eol && (st == ST_BODY);
    assign wr_en     = body_char && hx[4] && nib_odd;
    assign last_rd   = (CW'(rd_idx) + CW'(2)) == buf_count;

    mcs_line_index #(.PERIOD(PERIOD)) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (line_end),
        .keep    (keep)
    );

    mcs_line_store #(.DEPTH(MAX_BYTES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (line_start),
        .wr_en   (wr_en),
        .wr_data ({nib_hi, hx[3:0]}),
        .rd_idx  (rd_idx),
        .rd_data (buf_rd),
        .count   (buf_count),
        .full    (buf_full)
    );

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_WAIT: begin
                if (eof)
                    st_nx = ST_STOP;
                else if (in_valid && !in_eol)
                    st_nx = pend_emit ? ST_SEND : ST_HEAD;
            end
            ST_HEAD: begin
                if (eof)
                    st_nx = ST_STOP;
                else if (in_fire && in_eol)
                    st_nx = ST_WAIT;
                else if (in_fire && pre_cnt == PW'(PREFIX - 1))
                    st_nx = ST_BODY;
            end
            ST_BODY: begin
                if (eof)
                    st_nx = ST_STOP;
                else if (in_fire && in_eol)
                    st_nx = ST_WAIT;
            end
            ST_SEND: begin
                if (out_ready && last_rd)
                    st_nx = ST_HEAD;
            end
            ST_STOP: st_nx = ST_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_WAIT;
        else
            st <= st_nx;
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (st)
            ST_WAIT: in_ready  = in_valid && in_eol && !eof;
            ST_HEAD,
            ST_BODY: in_ready  = !eof;
            ST_SEND: out_valid = 1'b1;
            ST_STOP: in_ready  = 1'b0;
        endcase
    end

    assign out_data = buf_rd;
    assign fmt_err  = err_q;

    // line datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt   <= '0;
            nib_odd   <= 1'b0;
            nib_hi    <= '0;
            pend_emit <= 1'b0;
            rd_idx    <= '0;
            err_q     <= 1'b0;
        end else begin
            if (line_start) begin
                pre_cnt   <= '0;
                nib_odd   <= 1'b0;
                pend_emit <= 1'b0;
            end else begin
                if (st == ST_HEAD && in_fire && !in_eol)
                    pre_cnt <= pre_cnt + 1'b1;
                if (body_char && hx[4]) begin
                    nib_odd <= !nib_odd;
                    if (!nib_odd)
                        nib_hi <= hx[3:0];
                end
                if (line_end)
                    pend_emit <= keep && (buf_count >= CW'(2));
            end
            if (st == ST_WAIT && st_nx == ST_SEND)
                rd_idx <= '0;
            else if (out_fire)
                rd_idx <= rd_idx + 1'b1;
            if ((body_char && !hx[4]) ||
                (line_end && st == ST_BODY && nib_odd) ||
                (wr_en && buf_full))
                err_q <= 1'b1;
        end
    end

    // R8: a stalled byte is held
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R9: error flag never clears without reset
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |=> fmt_err);

    // R3: after end-of-file the input stays closed
    assert_stop_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_STOP |=> st == ST_STOP && !in_ready);

    // R7: emission starts only after a next-line character was offered and held off
    assert_emit_after_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid) && !$past(in_ready));

endmodule

// File: tb/mcs_strip_bench.sv
module mcs_strip_bench;

    localparam int NL = 6;
    localparam int TW = 256;

    // stimulus table: line text, length, ending code, bytes it contributes
    // ending: 0 CRLF, 1 LF, 2 CR, 3 CRLF followed by a blank CRLF
    localparam logic [TW-1:0] LTXT [NL] = '{
        TW'(":020000040000FA"),
        TW'(":04000000A1B2C3D47E"),
        TW'(":0300100012ab3F9c"),
        TW'(":020000040001F9"),
        TW'(":0200200055AA33"),
        TW'(":00000001FF")
    };
    localparam int LLEN [NL] = '{15, 19, 17, 15, 15, 11};
    localparam int LEND [NL] = '{0, 1, 3, 2, 0, 0};
    localparam int LCNT [NL] = '{0, 4, 3, 0, 2, 0};
    localparam logic [7:0] EXPB [9] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4,
                                        8'h12, 8'hAB, 8'h3F, 8'h55, 8'hAA};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       eof = 1'b0;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic       fmt_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rx_n = 0;
    logic [7:0] rx [64];
    bit finished = 0;

    always #2 clk = ~clk;

    mcs_strip #(.PERIOD(3), .PREFIX(9), .MAX_BYTES(8)) u_mcs_strip (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .eof       (eof),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .fmt_err   (fmt_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        out_ready <= ((cyc % 3) != 1);
    end

    always @(negedge clk) begin
        if (!rst_n)
            rx_n = 0;
        else if (out_valid && out_ready && rx_n < 64) begin
            rx[rx_n] = out_data;
            rx_n++;
        end
    end

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    task automatic put_char(input logic [7:0] c);
        bit hs;
        hs = 0;
        in_data  = c;
        in_valid = 1'b1;
        while (!hs) begin
            @(negedge clk);
            hs = in_ready;
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
    endtask

    task automatic send_line(input logic [TW-1:0] t, input int n, input int e);
        for (int i = 0; i < n; i++)
            put_char(t[8*(n-1-i) +: 8]);
        if (e == 0 || e == 2 || e == 3) put_char(8'h0D);
        if (e == 0 || e == 1 || e == 3) put_char(8'h0A);
        if (e == 3) begin
            put_char(8'h0D);
            put_char(8'h0A);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        eof = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic pulse_eof();
        eof = 1'b1;
        @(posedge clk);
        #1;
        eof = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(posedge clk);
        #1;
    endtask

    initial begin
        int cum;
        do_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 out_valid after reset", int'(out_valid), 0);
        chk(fmt_err == 1'b0, "R10 fmt_err after reset", int'(fmt_err), 0);

        // table walk: R1 header, R2 periodic drop, R5 blank line, R7 lookahead
        cum = 0;
        for (int k = 0; k < NL; k++) begin
            send_line(LTXT[k], LLEN[k], LEND[k]);
            settle();
            chk(rx_n == cum, $sformatf("R7 R2 R5 R1 bytes after line %0d", k), rx_n, cum);
            cum += LCNT[k];
        end
        pulse_eof();
        settle();
        chk(rx_n == 9, "R3 trailer dropped, total count", rx_n, 9);
        for (int b = 0; b < 9; b++)
            chk(rx[b] == EXPB[b], $sformatf("R6 R4 byte %0d", b), int'(rx[b]), int'(EXPB[b]));
        chk(fmt_err == 1'b0, "R9 no error on clean file", int'(fmt_err), 0);
        in_data = 8'h3A;
        in_valid = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b0, "R3 input closed after eof", int'(in_ready), 0);
        @(posedge clk);
        #1;
        in_valid = 1'b0;

        // R1: data-looking first line; R3: last data line dropped at eof
        do_reset();
        send_line(TW'(":0400000011223344AA"), 19, 0);
        send_line(TW'(":02000000BEEF00"), 15, 1);
        settle();
        chk(rx_n == 0, "R7 line held before next line", rx_n, 0);
        send_line(TW'(":02000000C0DE11"), 15, 0);
        settle();
        chk(rx_n == 2, "R1 only second line emitted", rx_n, 2);
        chk(rx[0] == 8'hBE, "R1 R6 first byte", int'(rx[0]), 'hBE);
        chk(rx[1] == 8'hEF, "R4 checksum removed", int'(rx[1]), 'hEF);
        pulse_eof();
        settle();
        chk(rx_n == 2, "R3 pending data line dropped at eof", rx_n, 2);

        // R9 error cases
        do_reset();
        send_line(TW'(":020000040000FA"), 15, 0);
        send_line(TW'(":02000000G1EF00"), 15, 1);
        chk(fmt_err == 1'b1, "R9 non-hex digit", int'(fmt_err), 1);
        send_line(TW'(":02000000ABCD00"), 15, 0);
        chk(fmt_err == 1'b1, "R9 error stays set", int'(fmt_err), 1);
        do_reset();
        @(negedge clk);
        chk(fmt_err == 1'b0, "R10 reset clears error", int'(fmt_err), 0);
        @(posedge clk);
        #1;
        send_line(TW'(":020000040000FA"), 15, 0);
        send_line(TW'(":0100000012345"), 14, 0);
        chk(fmt_err == 1'b1, "R9 odd digit count", int'(fmt_err), 1);
        do_reset();
        send_line(TW'(":020000040000FA"), 15, 0);
        send_line(TW'(":090000000102030405060708090A"), 29, 0);
        chk(fmt_err == 1'b1, "R9 line longer than store", int'(fmt_err), 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule